// File: doc/BRIEF.md
# Receive Byte Delimiter for External Address Filtering

This block sits on the decoded serial receive path of a 10 Mb/s Ethernet-style link and helps an external address filter follow each incoming frame one bit at a time. It runs on the bit clock, with one received bit per cycle. It watches the bit stream for an alternating preamble that ends in two consecutive ones. Once it finds that start delimiter, it drives a byte-delimiter square wave. Each rising edge of that wave falls on the first bit of a byte, and the first rising edge falls on the first bit of the destination address.

The block also forwards the serial data and a serial-activity qualifier to the external filter. It then merges the filter's active-low reject input with the internal address-match verdict into one accept or reject decision per frame. That decision is reported as a single-cycle pulse after receive-valid falls.

Line decoding, CRC checking and the address matching itself are not part of this block.

Top module: `rx_bytemark`

## Requirements
- R1: While reset is held and in the first cycle after it, `delim`, `frame_done` and `frame_reject` are 0.
- R2: A start delimiter is a received 1 whose previous bit was also 1, where the alternating run ending at that previous bit is at least MIN_ALT bits long (default 4). In the cycle after the second 1 is clocked in, `delim` is high, and it stays high for exactly BYTE_BITS/2 cycles (4 by default).
- R3: After the first high phase, `delim` toggles every BYTE_BITS/2 cycles. Its rising edges appear in the cycles where bit offsets 0, 8, 16 and so on after the delimiter are on `rx_data`, with offset 0 being the first destination address bit.
- R4: Once a start delimiter is found, no further search is made until `rx_valid` drops. A payload of all ones does not disturb the phase of `delim`.
- R5: When `rx_valid` is low, `delim` is low in that same cycle, with no clock edge needed. The bit counter is cleared, and the next frame is detected afresh.
- R6: While `tx_active` is 1, `delim` is low and no start delimiter is detected, so a frame received entirely during transmit gives no `frame_done`.
- R7: While `enable` is 0, `delim`, `ser_data` and `ser_active` are 0, and `reject_n` has no effect on the verdict. Detection and the verdict still run.
- R8: `frame_done` is a one-cycle pulse. It comes in the cycle after the first clock edge that samples `rx_valid` low, and only for a frame in which a start delimiter was found. In that cycle, `frame_reject` is 1 (reject) if `int_reject` was 1, or (with `enable` set) `reject_n` was 0, in any cycle where `rx_valid` was 1. Otherwise it is 0 (accept). `reject_n` is ignored while `rx_valid` is 0.
- R9: With the default twisted-pair variant (PORT_TP=1) and `enable` set, `ser_data` equals `rx_data` and `ser_active` is 1 while `rx_valid` is 1. Both outputs are 0 while `rx_valid` is 0.
- R10: If the alternating run before the two ones is shorter than MIN_ALT, that frame raises no `delim` and no `frame_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one received bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Enables the external filter outputs and the external reject |
| tx_active | input | 1 | Station is transmitting |
| rx_valid | input | 1 | Receive data qualifier |
| rx_data | input | 1 | Decoded NRZ receive bit |
| reject_n | input | 1 | External filter reject, active low |
| int_reject | input | 1 | Internal address-match reject verdict |
| delim | output | 1 | Byte-delimiter square wave |
| ser_data | output | 1 | Forwarded serial receive data |
| ser_active | output | 1 | Serial activity qualifier for the external filter |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| frame_reject | output | 1 | Frame verdict, 1 means reject |

## Verification
A wrong hunt state shows up at once as a missing `delim` rise, or as a rise on an offset that is not a multiple of eight. A corrupt phase counter shows up as an uneven half-period within four bit times of the fault. A bad reject accumulator stays hidden until the next `frame_done`, so every OR combination of the external and internal sources is driven at random bit positions and checked at the pulse. Frames sent with transmit active, with `enable` clear, and with too short a preamble are checked to make sure nothing appears that should not.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
   typedef enum logic {
      ST_HUNT  = 1'b0,
      ST_FRAME = 1'b1
   } hunt_st_t;

   function automatic int cnt_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/rbm_sfd_hunt.sv
module rbm_sfd_hunt
   import rbm_pkg::*;
#(
   parameter int MIN_ALT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic rx_valid,
   input  logic rx_data,
   output logic sfd_hit,
   output logic in_frame
);
   localparam int AW = cnt_width(MIN_ALT + 1);

   hunt_st_t        st;
   logic            prev_bit;
   logic            prev_ok;
   logic [AW-1:0]   alt_run;
   logic            alt_enough;

   assign alt_enough = (alt_run >= AW'(MIN_ALT));
   assign sfd_hit    = (st == ST_HUNT) && arm && rx_valid && rx_data &&
                       prev_ok && prev_bit && alt_enough;
   assign in_frame   = (st == ST_FRAME);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_HUNT;
         prev_bit <= 1'b0;
         prev_ok  <= 1'b0;
         alt_run  <= '0;
      end else if (!rx_valid) begin
         st       <= ST_HUNT;
         prev_bit <= 1'b0;
         prev_ok  <= 1'b0;
         alt_run  <= '0;
      end else begin
         prev_bit <= rx_data;
         prev_ok  <= 1'b1;
         if (!prev_ok || (rx_data == prev_bit))
            alt_run <= AW'(1);
         else if (!alt_enough)
            alt_run <= alt_run + AW'(1);
         if (sfd_hit)
            st <= ST_FRAME;
      end
   end
endmodule

// File: rtl/rbm_delim_gen.sv
module rbm_delim_gen
   import rbm_pkg::*;
#(
   parameter int HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sfd_hit,
   input  logic in_frame,
   output logic delim_q
);
   localparam int CW = cnt_width(HALF);
   localparam logic [CW-1:0] LAST = CW'(HALF - 1);

   logic [CW-1:0] phase;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         delim_q <= 1'b0;
         phase   <= '0;
      end else if (sfd_hit) begin
         delim_q <= 1'b1;
         phase   <= '0;
      end else if (in_frame) begin
         if (phase == LAST) begin
            phase   <= '0;
            delim_q <= ~delim_q;
         end else begin
            phase <= phase + CW'(1);
         end
      end else begin
         delim_q <= 1'b0;
         phase   <= '0;
      end
   end
endmodule

// File: rtl/rbm_verdict.sv
module rbm_verdict (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic rx_valid,
   input  logic in_frame,
   input  logic reject_n,
   input  logic int_reject,
   output logic frame_done,
   output logic frame_reject
);
   logic valid_q;
   logic ext_acc;
   logic int_acc;
   logic fall;

   assign fall = valid_q && !rx_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q      <= 1'b0;
         ext_acc      <= 1'b0;
         int_acc      <= 1'b0;
         frame_done   <= 1'b0;
         frame_reject <= 1'b0;
      end else begin
         valid_q    <= rx_valid;
         frame_done <= fall && in_frame;
         if (fall) begin
            frame_reject <= ext_acc | int_acc;
            ext_acc      <= 1'b0;
            int_acc      <= 1'b0;
         end else if (rx_valid) begin
            ext_acc <= ext_acc | (enable & ~reject_n);
            int_acc <= int_acc | int_reject;
         end
      end
   end
endmodule

// File: rtl/rx_bytemark.sv
module rx_bytemark
   import rbm_pkg::*;
#(
   parameter int BYTE_BITS = 8,
   parameter int MIN_ALT   = 4,
   parameter bit PORT_TP   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic tx_active,
   input  logic rx_valid,
   input  logic rx_data,
   input  logic reject_n,
   input  logic int_reject,
   output logic delim,
   output logic ser_data,
   output logic ser_active,
   output logic frame_done,
   output logic frame_reject
);
   localparam int HALF = BYTE_BITS / 2;

   if ((BYTE_BITS < 2) || ((BYTE_BITS % 2) != 0)) begin : g_bad_byte
      $error("rx_bytemark: BYTE_BITS must be even and at least 2");
   end
   if (MIN_ALT < 1) begin : g_bad_alt
      $error("rx_bytemark: MIN_ALT must be at least 1");
   end

   logic sfd_hit;
   logic in_frame;
   logic delim_q;
   logic hunt_arm;

   assign hunt_arm = ~tx_active;

   rbm_sfd_hunt #(.MIN_ALT(MIN_ALT)) u_hunt (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (hunt_arm),
      .rx_valid (rx_valid),
      .rx_data  (rx_data),
      .sfd_hit  (sfd_hit),
      .in_frame (in_frame)
   );

   rbm_delim_gen #(.HALF(HALF)) u_delim (
      .clk      (clk),
      .rst_n    (rst_n),
      .sfd_hit  (sfd_hit),
      .in_frame (in_frame),
      .delim_q  (delim_q)
   );

   rbm_verdict u_verdict (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (enable),
      .rx_valid     (rx_valid),
      .in_frame     (in_frame),
      .reject_n     (reject_n),
      .int_reject   (int_reject),
      .frame_done   (frame_done),
      .frame_reject (frame_reject)
   );

   assign delim = delim_q & rx_valid & enable & ~tx_active;

   if (PORT_TP) begin : g_tp
      assign ser_data   = enable & rx_valid & rx_data;
      assign ser_active = enable & rx_valid;
   end else begin : g_aui
      assign ser_data   = enable & rx_data;
      assign ser_active = enable & (rx_valid | tx_active);
   end
endmodule

// File: rtl/rx_bytemark_chk.sv
module rx_bytemark_chk #(
   parameter int BYTE_BITS = 8,
   parameter bit PORT_TP   = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic tx_active,
   input logic rx_valid,
   input logic delim,
   input logic ser_data,
   input logic frame_done
);
   localparam int HALF = BYTE_BITS / 2;
   localparam int RW   = $clog2(HALF + 2);

   logic [RW-1:0] high_run;

   always_ff @(posedge clk) begin
      if (!rst_n)
         high_run <= '0;
      else if (delim && (high_run <= RW'(HALF)))
         high_run <= high_run + RW'(1);
      else if (!delim)
         high_run <= '0;
   end

   p_half_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      delim |-> (high_run < RW'(HALF)));

   p_drop_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> !delim);

   p_tx_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_active |-> !delim);

   p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (!delim && !ser_data));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   p_done_after_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> !$past(rx_valid));

   if (PORT_TP) begin : g_tp_chk
      p_ser_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !rx_valid |-> !ser_data);
   end
endmodule

bind rx_bytemark rx_bytemark_chk #(.BYTE_BITS(BYTE_BITS), .PORT_TP(PORT_TP)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .tx_active  (tx_active),
   .rx_valid   (rx_valid),
   .delim      (delim),
   .ser_data   (ser_data),
   .frame_done (frame_done)
);

// File: tb/sim_rx_bytemark.sv
module sim_rx_bytemark;
   localparam int HALF = 4;

   logic clk = 1'b0;
   logic rst_n, enable, tx_active, rx_valid, rx_data, reject_n, int_reject;
   logic delim, ser_data, ser_active, frame_done, frame_reject;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   bit bits [0:299];

   always #10 clk = ~clk;

   rx_bytemark u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .tx_active(tx_active),
      .rx_valid(rx_valid), .rx_data(rx_data), .reject_n(reject_n),
      .int_reject(int_reject), .delim(delim), .ser_data(ser_data),
      .ser_active(ser_active), .frame_done(frame_done),
      .frame_reject(frame_reject)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit exp_delim(input int k, input bit active);
      return active && (k >= 0) && (((k / HALF) % 2) == 0);
   endfunction

   // mode: 0 random payload, 1 all zeros, 2 all ones
   task automatic run_frame(input int pre, input int nb, input int mode,
                            input bit ext_rej, input bit int_rej,
                            input bit en, input bit tx, input bit good_pre,
                            input string tag);
      int L, s, r1, r2, derr, serr, rises, bad_off;
      bit prev_d, e_act, e_done, e_rej;
      L = 2*pre + 2 + 8*nb;
      s = 2*pre + 1;
      for (int i = 0; i < 2*pre; i++) bits[i] = (i % 2 == 0);
      bits[2*pre] = 1'b1;
      bits[2*pre+1] = 1'b1;
      for (int i = s + 1; i < L; i++)
         bits[i] = (mode == 1) ? 1'b0 : (mode == 2) ? 1'b1 : 1'($urandom_range(0, 1));
      r1 = $urandom_range(0, L - 1);
      r2 = $urandom_range(0, L - 1);
      e_act  = good_pre && en && !tx;
      e_done = good_pre && !tx;
      e_rej  = int_rej || (ext_rej && en);
      derr = 0; serr = 0; rises = 0; bad_off = 0; prev_d = 1'b0;
      enable = en;
      tx_active = tx;
      for (int i = 0; i <= L; i++) begin
         @(negedge clk);
         if (i > 0) begin
            if (delim !== exp_delim(i - 1 - s, e_act)) derr++;
            if ((ser_data !== (en & bits[i-1])) || (ser_active !== en)) serr++;
            if (delim && !prev_d) begin
               rises++;
               if (((i - (s + 1)) % 8) != 0) bad_off++;
            end
            prev_d = delim;
         end
         if (i < L) begin
            rx_valid   = 1'b1;
            rx_data    = bits[i];
            reject_n   = !(ext_rej && (i == r1));
            int_reject = int_rej && (i == r2);
         end else begin
            rx_valid = 1'b0; rx_data = 1'b0; reject_n = 1'b1; int_reject = 1'b0;
         end
      end
      chk(derr == 0, {"R2/R3 delim waveform ", tag}, derr, 0);
      chk(rises == (e_act ? nb + 1 : 0), {"R3 rise count ", tag}, rises, e_act ? nb + 1 : 0);
      chk(bad_off == 0, {"R3 rise offsets ", tag}, bad_off, 0);
      chk(serr == 0, {"R9 serial forward ", tag}, serr, 0);
      #1;
      chk((delim == 1'b0) && (ser_data == 1'b0) && (ser_active == 1'b0),
          {"R5/R9 drop ", tag}, delim, 0);
      @(negedge clk);
      chk(frame_done == e_done, {"R8 done ", tag}, frame_done, e_done);
      if (e_done) chk(frame_reject == e_rej, {"R8 verdict ", tag}, frame_reject, e_rej);
      @(negedge clk);
      chk(frame_done == 1'b0, {"R8 one-cycle ", tag}, frame_done, 0);
   endtask

   initial begin
      void'($urandom(32'd1234));
      rst_n = 1'b0; enable = 1'b1; tx_active = 1'b0; rx_valid = 1'b0;
      rx_data = 1'b0; reject_n = 1'b1; int_reject = 1'b0;
      repeat (4) @(negedge clk);
      chk({delim, frame_done, frame_reject} == 3'b000, "R1 reset", {delim, frame_done, frame_reject}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({delim, frame_done, frame_reject} == 3'b000, "R1 after reset", {delim, frame_done, frame_reject}, 0);

      run_frame(2, 3, 2, 0, 0, 1, 0, 1, "R4 ones payload");
      run_frame(1, 2, 1, 0, 0, 1, 0, 0, "R10 short preamble");
      run_frame(4, 2, 0, 0, 0, 1, 1, 1, "R6 during transmit");
      run_frame(3, 2, 0, 1, 0, 0, 0, 1, "R7 disabled ext ignored");
      enable = 1'b1;
      tx_active = 1'b0;
      reject_n = 1'b0;
      repeat (3) @(negedge clk);
      reject_n = 1'b1;
      run_frame(3, 2, 0, 0, 0, 1, 0, 1, "R8 idle reject ignored");
      run_frame(5, 2, 0, 0, 0, 1, 0, 1, "R8 none");
      run_frame(5, 2, 0, 1, 0, 1, 0, 1, "R8 ext only");
      run_frame(5, 2, 0, 0, 1, 1, 0, 1, "R8 int only");
      run_frame(5, 2, 0, 1, 1, 1, 0, 1, "R8 both");
      for (int n = 0; n < 24; n++)
         run_frame($urandom_range(2, 10), $urandom_range(1, 6), 0,
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                   1'b1, 1'b0, 1'b1, "R5 random re-arm");
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule